// File: doc/BRIEF.md
# Byte-Wide Flash Rewrite Sequencer

This block rewrites the entire contents of an external byte-wide, electrically erasable memory by driving its pins directly. A run has three phases. First it erases the whole array with a single long strobe while both high-voltage enables are raised. Next it performs a blank check, reading every address in ascending order and requiring each byte to read back as all ones. Finally it programs the array one byte at a time in ascending address order. For each byte it takes the value from a valid/ready source stream, applies one short strobe under the programming supply only, and then reads the byte back to confirm it.

The high-voltage enables are ordinary digital outputs; a board-level switch is expected to turn them into real supply levels. Before every read the block drops both enables and waits a settle time. It then holds chip enable and output enable low for an access delay before it samples the data bus. Pulse lengths, access delay and settle time are parameters counted in clock cycles. Their defaults come from a 5 ns clock: a 100 ms erase pulse, a 20 us program pulse and a 70 ns access delay rounded up.

The source port follows the usual valid/ready rules. A byte moves on a clock edge where both `src_valid` and `src_ready` are high. Once the source raises `src_valid`, it keeps the signal high and `src_data` stable until that edge. The block never raises `src_ready` outside the wait for the next byte, so the source sees back-pressure for the whole erase, the blank check and each program/verify slot. Any read-back mismatch latches the failing address, the expected byte and the read byte, raises the error flag and ends the run. Abort ends a run at once.

Top module: `mtp_rewrite_seq`

## Requirements
- R1: The erase strobe is driven low exactly ERASE_CYC consecutive cycles. During it both high-voltage enables are high, chip enable is low and output enable is high. The erase happens once per run, before any read.
- R2: After the erase, every address from 0 up to the last one is read once in ascending order. A byte other than all ones stops the run with `err`=1, `err_addr` set to that address, `err_exp`=FFh and `err_act` set to the byte read. In that case no source byte is requested and nothing is programmed.
- R3: Each program strobe lasts exactly PULSE_CYC cycles. During it only the programming-supply enable is high (the identification enable is low), chip enable is low, output enable is high, and the bus drives the source byte for the current address.
- R4: Bytes are programmed at ascending addresses starting from 0, one source byte per address. After the last address is verified, `done`=1, `busy`=0 and `prog_count` equals 2^ADDR_W.
- R5: During any read both high-voltage enables are low, chip enable and output enable are low, and the bus is not driven. The data is sampled at the end of the ACCESS_CYC-th cycle of the read.
- R6: Both high-voltage enables are low for at least SETTLE_CYC cycles before every read begins.
- R7: When a program read-back differs from the source byte, the block sets `err`=1, latches the address and both bytes, returns to idle, and counts only the bytes verified before it.
- R8: A cycle with `abort` high is followed by a cycle in which both enables are low, the strobe is high and `busy`=0.
- R9: `src_ready` is high only while the block waits for the next byte to program, and is low whenever `abort` is high. A byte is consumed only on a cycle with valid and ready both high.
- R10: `start` is taken only when idle. Taking it clears `done`, `err` and `prog_count` by the next cycle. A `start` pulse while busy neither restarts nor disturbs the run.
- R11: After reset all memory pins are inactive (chip enable, output enable and strobe high, enables low, bus released), and `busy`, `done`, `err`, `src_ready` and `prog_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a rewrite run (taken when idle) |
| abort | input | 1 | End the current run immediately |
| src_valid | input | 1 | Source byte available |
| src_ready | output | 1 | Block accepts a source byte this cycle |
| src_data | input | DATA_W | Source byte |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_out | output | DATA_W | Byte driven onto the memory bus |
| mem_dq_drive | output | 1 | Bus output enable toward the memory |
| mem_dq_in | input | DATA_W | Byte read from the memory bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| prog_strobe_n | output | 1 | Erase/program strobe, active low |
| hv_supply_en | output | 1 | Request for the programming supply voltage |
| hv_id_en | output | 1 | Request for the high voltage on the erase-select address pin |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished with every byte verified |
| err | output | 1 | Last run stopped on a read-back mismatch |
| err_addr | output | ADDR_W | Address of the mismatch |
| err_exp | output | DATA_W | Byte expected at the mismatch |
| err_act | output | DATA_W | Byte read at the mismatch |
| prog_count | output | ADDR_W+1 | Bytes programmed and verified in this run |

## Verification
The memory model returns the bitwise inverse of the correct byte until a read has been held for the full access delay. A design that samples one cycle early therefore fails the blank check or the read-back at once. A stuck-low bit placed after the erase, and a separate stuck-high bit placed under programming, push the run into both error exits; a design that latched the wrong address or byte, or kept programming after the failure, would show the wrong `err_*` values or a nonzero ready count. Aborts are issued in the middle of the erase strobe and in the middle of a program strobe, and a design that let either enable or the strobe linger one cycle would be caught. A `start` pulse during programming checks that the count is not cleared and the run does not restart.

// File: rtl/mtp_seq_pkg.sv
package mtp_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ER_SET,
    S_ER_PULSE,
    S_BC_SET,
    S_BC_RD,
    S_PG_FETCH,
    S_PG_SET,
    S_PG_PULSE,
    S_PG_REC,
    S_PG_RD
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (clr)   addr <= '0;
    else if (inc)   addr <= addr + ADDR_W'(1);
  end

  assign last = &addr;

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !last);

endmodule

// File: rtl/seq_verify.sv
module seq_verify #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              check_en,
  input  logic [DATA_W-1:0] expect_b,
  input  logic [DATA_W-1:0] actual_b,
  input  logic [ADDR_W-1:0] addr,
  output logic              mismatch,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_exp,
  output logic [DATA_W-1:0] err_act
);

  assign mismatch = (actual_b != expect_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err      <= 1'b0;
      err_addr <= '0;
      err_exp  <= '0;
      err_act  <= '0;
    end else if (clear) begin
      err      <= 1'b0;
      err_addr <= '0;
      err_exp  <= '0;
      err_act  <= '0;
    end else if (check_en && mismatch) begin
      err      <= 1'b1;
      err_addr <= addr;
      err_exp  <= expect_b;
      err_act  <= actual_b;
    end
  end

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(check_en && mismatch));

endmodule

// File: rtl/mtp_rewrite_seq.sv
module mtp_rewrite_seq
  import mtp_seq_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int ERASE_CYC     = 100_000_000 / CLK_PERIOD_NS,
  parameter int PULSE_CYC     = 20_000 / CLK_PERIOD_NS,
  parameter int ACCESS_CYC    = (70 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS,
  parameter int SETTLE_CYC    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_drive,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              prog_strobe_n,
  output logic              hv_supply_en,
  output logic              hv_id_en,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_exp,
  output logic [DATA_W-1:0] err_act,
  output logic [ADDR_W:0]   prog_count
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = imax(imax(ERASE_CYC, PULSE_CYC), imax(ACCESS_CYC, SETTLE_CYC));
  localparam int TW    = $clog2(MAXC + 1);
  localparam logic [TW-1:0] LD_ERASE  = TW'(ERASE_CYC - 1);
  localparam logic [TW-1:0] LD_PULSE  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] LD_ACCESS = TW'(ACCESS_CYC - 1);
  localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 1);
  localparam logic [DATA_W-1:0] BLANK = '1;

  seq_state_e st, nxt;

  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          a_clr, a_inc, a_last;
  logic          chk_en, mism, take, fin, pass, go;
  logic [DATA_W-1:0] byte_q, exp_b;

  seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  seq_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc),
    .addr(mem_addr), .last(a_last)
  );

  assign exp_b = (st == S_BC_RD) ? BLANK : byte_q;

  seq_verify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_verify (
    .clk(clk), .rst_n(rst_n), .clear(go), .check_en(chk_en),
    .expect_b(exp_b), .actual_b(mem_dq_in), .addr(mem_addr),
    .mismatch(mism), .err(err), .err_addr(err_addr),
    .err_exp(err_exp), .err_act(err_act)
  );

  assign go = (st == S_IDLE) && start && !abort;

  // next-state and sequencing controls
  always_comb begin
    nxt    = st;
    t_load = 1'b0;
    t_val  = '0;
    a_clr  = 1'b0;
    a_inc  = 1'b0;
    chk_en = 1'b0;
    take   = 1'b0;
    fin    = 1'b0;
    pass   = 1'b0;
    if (abort) begin
      nxt = S_IDLE;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          nxt = S_ER_SET; t_load = 1'b1; t_val = LD_SETTLE; a_clr = 1'b1;
        end
        S_ER_SET: if (t_zero) begin
          nxt = S_ER_PULSE; t_load = 1'b1; t_val = LD_ERASE;
        end
        S_ER_PULSE: if (t_zero) begin
          nxt = S_BC_SET; t_load = 1'b1; t_val = LD_SETTLE;
        end
        S_BC_SET: if (t_zero) begin
          nxt = S_BC_RD; t_load = 1'b1; t_val = LD_ACCESS;
        end
        S_BC_RD: if (t_zero) begin
          chk_en = 1'b1;
          if (mism) nxt = S_IDLE;
          else if (a_last) begin
            nxt = S_PG_FETCH; a_clr = 1'b1;
          end else begin
            a_inc = 1'b1; t_load = 1'b1; t_val = LD_ACCESS;
          end
        end
        S_PG_FETCH: if (src_valid) begin
          nxt = S_PG_SET; take = 1'b1; t_load = 1'b1; t_val = LD_SETTLE;
        end
        S_PG_SET: if (t_zero) begin
          nxt = S_PG_PULSE; t_load = 1'b1; t_val = LD_PULSE;
        end
        S_PG_PULSE: if (t_zero) begin
          nxt = S_PG_REC; t_load = 1'b1; t_val = LD_SETTLE;
        end
        S_PG_REC: if (t_zero) begin
          nxt = S_PG_RD; t_load = 1'b1; t_val = LD_ACCESS;
        end
        S_PG_RD: if (t_zero) begin
          chk_en = 1'b1;
          if (mism) nxt = S_IDLE;
          else begin
            pass = 1'b1;
            if (a_last) begin
              nxt = S_IDLE; fin = 1'b1;
            end else begin
              nxt = S_PG_FETCH; a_inc = 1'b1;
            end
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      byte_q     <= '0;
      done       <= 1'b0;
      prog_count <= '0;
    end else begin
      st <= nxt;
      if (take) byte_q <= src_data;
      if (go)        done <= 1'b0;
      else if (fin)  done <= 1'b1;
      if (go)        prog_count <= '0;
      else if (pass) prog_count <= prog_count + (ADDR_W+1)'(1);
    end
  end

  // pin decode from state
  always_comb begin
    mem_ce_n      = 1'b1;
    mem_oe_n      = 1'b1;
    prog_strobe_n = 1'b1;
    hv_supply_en  = 1'b0;
    hv_id_en      = 1'b0;
    mem_dq_drive  = 1'b0;
    unique case (st)
      S_ER_SET: begin
        hv_supply_en = 1'b1; hv_id_en = 1'b1; mem_ce_n = 1'b0;
      end
      S_ER_PULSE: begin
        hv_supply_en = 1'b1; hv_id_en = 1'b1; mem_ce_n = 1'b0; prog_strobe_n = 1'b0;
      end
      S_BC_RD, S_PG_RD: begin
        mem_ce_n = 1'b0; mem_oe_n = 1'b0;
      end
      S_PG_SET: begin
        hv_supply_en = 1'b1; mem_ce_n = 1'b0; mem_dq_drive = 1'b1;
      end
      S_PG_PULSE: begin
        hv_supply_en = 1'b1; mem_ce_n = 1'b0; mem_dq_drive = 1'b1; prog_strobe_n = 1'b0;
      end
      default: ;
    endcase
  end

  assign mem_dq_out = byte_q;
  assign src_ready  = (st == S_PG_FETCH) && !abort;
  assign busy       = (st != S_IDLE);

  // R1
  strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_strobe_n |-> (!mem_ce_n && mem_oe_n && hv_supply_en));

  // R3
  prog_id_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_strobe_n && mem_dq_drive) |-> !hv_id_en);

  // R5
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!hv_supply_en && !hv_id_en && !mem_dq_drive));

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!hv_supply_en && !hv_id_en && prog_strobe_n && !busy));

  // R9
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (!hv_supply_en && !hv_id_en && prog_strobe_n && !abort));

  // R4
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (prog_count == (ADDR_W+1)'(DEPTH)));

endmodule

// File: tb/sim_mtp_rewrite_seq.sv
`timescale 1ns/1ps
module sim_mtp_rewrite_seq;

  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int ER = 20;
  localparam int PU = 6;
  localparam int AC = 3;
  localparam int SE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic src_valid = 1'b0;
  logic [7:0] src_data = '0;
  logic src_ready;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_dq_out, dq_in_b;
  logic mem_dq_drive, mem_ce_n, mem_oe_n, prog_strobe_n, hv_supply_en, hv_id_en;
  logic busy, done, err;
  logic [AW-1:0] err_addr;
  logic [7:0] err_exp, err_act;
  logic [AW:0] prog_count;

  always #2.5 clk = ~clk;

  mtp_rewrite_seq #(.ADDR_W(AW), .DATA_W(8), .ERASE_CYC(ER), .PULSE_CYC(PU),
                    .ACCESS_CYC(AC), .SETTLE_CYC(SE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
    .mem_dq_in(dq_in_b), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .prog_strobe_n(prog_strobe_n), .hv_supply_en(hv_supply_en), .hv_id_en(hv_id_en),
    .busy(busy), .done(done), .err(err), .err_addr(err_addr),
    .err_exp(err_exp), .err_act(err_act), .prog_count(prog_count)
  );

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural memory and source model
  logic [7:0] mem [DEPTH];
  logic [7:0] src_bytes [DEPTH];
  int src_idx = 0, prog_idx = 0, ready_seen = 0;
  bit src_pend = 0, abort_prev = 0, abort_recent = 0;
  bit prev_read = 0, prev_low = 0, pulse_erase = 0;
  int rd_cnt = 0, plen = 0, hv_off = 0;
  logic [AW-1:0] prev_addr = '0;
  int stk0_addr = 0, stk1_addr = 0;
  logic [7:0] stk0_mask = 8'h00, stk1_mask = 8'h00;

  function automatic logic [7:0] rd_val(input int a);
    logic [7:0] v;
    v = mem[a];
    if (a == stk0_addr) v = v & ~stk0_mask;
    if (a == stk1_addr) v = v | stk1_mask;
    return v;
  endfunction

  always @(negedge clk) begin
    bit rd;
    logic [7:0] v;
    if (!rst_n) begin
      rd_cnt = 0; plen = 0; hv_off = 0; prev_read = 0; prev_low = 0;
      abort_prev = 0; dq_in_b = 8'h00;
    end else begin
      rd = !mem_ce_n && !mem_oe_n;
      if (!mem_oe_n) chk("R5 enables off in read", {30'd0, hv_supply_en, hv_id_en}, 0);
      if (!mem_oe_n) chk("R5 bus released in read", {31'd0, mem_dq_drive}, 0);
      if (!prog_strobe_n) chk("R1/R3 strobe pin mode", {29'd0, mem_ce_n, mem_oe_n, hv_supply_en}, 3'b011);
      if (src_ready) begin
        ready_seen++;
        chk("R9 ready only in fetch", {29'd0, hv_supply_en, hv_id_en, prog_strobe_n}, 3'b001);
      end
      if (abort_prev) chk("R8 abort quiets pins", {28'd0, hv_supply_en, hv_id_en, prog_strobe_n, busy}, 4'b0010);
      if (hv_supply_en || hv_id_en) hv_off = 0; else hv_off++;
      if (rd && !prev_read) chk("R6 settle before read", {31'd0, (hv_off >= SE + 1)}, 1);
      if (rd && prev_read && mem_addr == prev_addr) rd_cnt++; else rd_cnt = 0;
      // strobe tracking
      if (!prog_strobe_n) begin
        plen++;
        pulse_erase = hv_id_en;
      end else if (prev_low) begin
        if (!abort_recent) begin
          if (pulse_erase) begin
            chk("R1 erase pulse length", plen, ER);
            for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
          end else begin
            chk("R3 program pulse length", plen, PU);
            chk("R4 program address order", {29'd0, mem_addr}, prog_idx);
            chk("R3 program data", {24'd0, mem_dq_out}, {24'd0, src_bytes[prog_idx % DEPTH]});
            mem[mem_addr] = mem[mem_addr] & mem_dq_out;
            prog_idx++;
          end
        end
        plen = 0;
      end
      prev_low = !prog_strobe_n;
      v = rd_val(int'(mem_addr));
      dq_in_b = (rd && rd_cnt >= AC - 1) ? v : ~v;
      prev_read = rd;
      prev_addr = mem_addr;
      abort_prev = abort;
      if (abort) abort_recent = 1;
      // source driver
      if (src_pend) begin
        src_idx++; src_pend = 0; src_valid = 1'b0;
      end
      if (!src_valid && src_idx < DEPTH && ($urandom % 3 != 0)) begin
        src_valid = 1'b1; src_data = src_bytes[src_idx];
      end
      if (src_valid && src_ready) src_pend = 1;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_start();
    tick();
    src_idx = 0; src_pend = 0; src_valid = 1'b0; prog_idx = 0;
    ready_seen = 0; abort_recent = 0;
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R10 start clears done", {31'd0, done}, 0);
    chk("R10 start clears err", {31'd0, err}, 0);
    chk("R10 start clears count", {28'd0, prog_count}, 0);
    chk("R10 start sets busy", {31'd0, busy}, 1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin tick(); n++; end
  endtask

  task automatic check_mem(input string tag);
    for (int i = 0; i < DEPTH; i++)
      chk(tag, {24'd0, rd_val(i)}, {24'd0, src_bytes[i]});
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'($urandom); src_bytes[i] = 8'($urandom); end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk("R11 reset pins", {26'd0, mem_ce_n, mem_oe_n, prog_strobe_n, hv_supply_en, hv_id_en, mem_dq_drive}, 6'b111000);
    chk("R11 reset status", {28'd0, busy, done, err, src_ready}, 0);
    chk("R11 reset count", {28'd0, prog_count}, 0);

    // R4 full run with random data
    do_start();
    wait_idle();
    chk("R4 done", {30'd0, done, err}, 2'b10);
    chk("R4 count", {28'd0, prog_count}, DEPTH);
    chk("R4 bytes programmed", prog_idx, DEPTH);
    check_mem("R4 contents run1");

    // R10 second run with patterned data and a start pulse while busy
    for (int i = 0; i < DEPTH; i++) src_bytes[i] = (i % 4 == 0) ? 8'h00 : (i % 4 == 1) ? 8'hFF : (i % 4 == 2) ? 8'hAA : 8'h55;
    do_start();
    begin
      int n = 0;
      while (prog_count < 2 && n < 5000) begin tick(); n++; end
    end
    start = 1'b1; tick(); start = 1'b0;
    chk("R10 start while busy ignored", {31'd0, busy}, 1);
    chk("R10 count kept while busy", {31'd0, (prog_count >= 2)}, 1);
    wait_idle();
    chk("R4 done run2", {30'd0, done, err}, 2'b10);
    chk("R4 count run2", {28'd0, prog_count}, DEPTH);
    check_mem("R4 contents run2");

    // R2 blank check failure
    stk0_addr = 5; stk0_mask = 8'h01;
    do_start();
    wait_idle();
    chk("R2 err set", {30'd0, done, err}, 2'b01);
    chk("R2 err addr", {29'd0, err_addr}, 5);
    chk("R2 err exp", {24'd0, err_exp}, 8'hFF);
    chk("R2 err act", {24'd0, err_act}, 8'hFE);
    chk("R2 nothing requested", ready_seen, 0);
    chk("R2 nothing programmed", {28'd0, prog_count}, 0);
    stk0_mask = 8'h00;

    // R7 program verify failure
    stk1_addr = 3; stk1_mask = 8'h80;
    for (int i = 0; i < DEPTH; i++) src_bytes[i] = 8'(8'h10 + i * 3);
    src_bytes[3] = 8'h12;
    do_start();
    wait_idle();
    chk("R7 err set", {30'd0, done, err}, 2'b01);
    chk("R7 err addr", {29'd0, err_addr}, 3);
    chk("R7 err exp", {24'd0, err_exp}, 8'h12);
    chk("R7 err act", {24'd0, err_act}, 8'h92);
    chk("R7 count before fail", {28'd0, prog_count}, 3);
    stk1_mask = 8'h00;

    // R8 abort during erase strobe
    do_start();
    begin
      int n = 0;
      while (prog_strobe_n && n < 500) begin tick(); n++; end
    end
    chk("R8 in erase pulse", {31'd0, hv_id_en}, 1);
    abort = 1'b1; tick(); abort = 1'b0;
    chk("R8 erase abort pins", {28'd0, hv_supply_en, hv_id_en, prog_strobe_n, busy}, 4'b0010);

    // R8 abort during a program strobe
    do_start();
    begin
      int n = 0;
      while (!(!prog_strobe_n && !hv_id_en) && n < 5000) begin tick(); n++; end
    end
    chk("R8 in program pulse", {31'd0, mem_dq_drive}, 1);
    abort = 1'b1; tick(); abort = 1'b0;
    chk("R8 program abort pins", {28'd0, hv_supply_en, hv_id_en, prog_strobe_n, busy}, 4'b0010);
    repeat (5) tick();
    chk("R8 stays idle", {31'd0, busy}, 0);

    // R9 clean run after aborts
    do_start();
    wait_idle();
    chk("R9 all bytes consumed", src_idx, DEPTH);
    chk("R4 done run3", {30'd0, done, err}, 2'b10);
    check_mem("R4 contents run3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule